// File: doc/BRIEF.md
# Error Capture Register Set with Attention Class Decode

This block gathers single-cycle error pulses from up to 52 hardware sources into a sticky 64-bit error register. Software reaches it through a small word-addressed register port. The error register sits beside a mask register and two action-select registers. Each error bit that is set and not masked is sorted into one of three attention classes by the pair of action bits at the same position. The OR of each class drives a registered attention output towards the service logic.

Software never needs a read-modify-write. Separate port offsets replace a register, AND the write data into it, or OR the write data into it. Software clears a handled error with the AND alias and silences a noisy source with the mask OR alias. The error OR alias lets software inject errors for testing.

Top module: `fir_attn_unit`

## Requirements
- R1: After reset the error register reads 0, the mask reads 64'hFFFF_FFFF_FFFF_F000 (every source bit set), both action registers read 0, and all three attention outputs are 0.
- R2: Source i (0..51) maps to register bit position 63-i, so source 0 is the MSB. The low 12 bit positions [11:0] always read 0, and write data in those positions has no effect.
- R3: A one-cycle pulse on a source input sets its error bit at the next clock edge. The bit stays set until a software write clears it.
- R4: Error register offsets: offset 0 replaces it with the write data, offset 1 ANDs the write data into it, and offset 2 ORs the write data into it.
- R5: Mask register offsets: offset 3 replaces it, offset 4 ANDs the write data into it, and offset 5 ORs the write data into it.
- R6: Offset 6 writes action register A and offset 7 writes action register B. A read returns the error register at offsets 0 to 2, the mask at offsets 3 to 5, and the addressed action register at offsets 6 and 7.
- R7: If a source pulse and an error-register write that would clear that bit land on the same clock edge, the bit ends up set.
- R8: `attn_sys_chk` is 1 when some bit is set in the error register and clear in the mask, in A and in B.
- R9: `attn_recov` is 1 when some bit is set in the error register, clear in the mask, clear in A and set in B.
- R10: `attn_unit_chk` is 1 when some bit is set in the error register, clear in the mask, set in A and set in B.
- R11: An unmasked error bit with A set and B clear raises no attention output.
- R12: The attention outputs come from a register. They reflect the error, mask and action state one clock edge after that state changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_pulse | input | 52 | Error source pulses, index = source number |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Word offset for both read and write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the addressed register (combinational) |
| attn_sys_chk | output | 1 | System checkstop attention |
| attn_recov | output | 1 | Recoverable attention |
| attn_unit_chk | output | 1 | Unit checkstop attention |

## Verification
A corrupted error, mask or action bit shows on `reg_rdata` as soon as the bench addresses that register. It also moves the attention outputs exactly one edge later. Running the class decode for each pairing of action bits on a single source shows a swapped or dropped class as the wrong attention on that next edge. A lost sticky bit or a lost pulse-versus-clear priority shows as a missing bit in the first read after the pulse.

// File: rtl/fir_attn_pkg.sv
package fir_attn_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFF_ERR     = 3'd0,
    OFF_ERR_AND = 3'd1,
    OFF_ERR_OR  = 3'd2,
    OFF_MSK     = 3'd3,
    OFF_MSK_AND = 3'd4,
    OFF_MSK_OR  = 3'd5,
    OFF_ACT_A   = 3'd6,
    OFF_ACT_B   = 3'd7
  } fir_off_e;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_SYS  = 2'd1,
    CLS_REC  = 2'd2,
    CLS_UNIT = 2'd3
  } fir_cls_e;

  // Register position of a source: source 0 is the MSB.
  function automatic int src_pos(input int data_w, input int src);
    return data_w - 1 - src;
  endfunction

  // Class of one bit position from its four register bits.
  function automatic fir_cls_e classify(input logic e, input logic m,
                                        input logic a, input logic b);
    fir_cls_e c;
    c = CLS_NONE;
    if (e && !m) begin
      case ({a, b})
        2'b00:   c = CLS_SYS;
        2'b01:   c = CLS_REC;
        2'b11:   c = CLS_UNIT;
        default: c = CLS_NONE;
      endcase
    end
    return c;
  endfunction

  // Positions that belong to a source.
  function automatic logic [63:0] valid_bits(input int data_w, input int n_src);
    logic [63:0] v;
    v = '0;
    for (int i = 0; i < n_src; i++) v[data_w-1-i] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/fir_src_map.sv
module fir_src_map #(
  parameter int DATA_W = 64,
  parameter int N_SRC  = 52
) (
  input  logic [N_SRC-1:0]  pulse,
  output logic [DATA_W-1:0] set_vec
);
  import fir_attn_pkg::*;

  localparam int N_PAD = DATA_W - N_SRC;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign set_vec[src_pos(DATA_W, i)] = pulse[i];
  end
  if (N_PAD > 0) begin : g_pad
    assign set_vec[N_PAD-1:0] = '0;
  end
endmodule

// File: rtl/fir_wr_reg.sv
module fir_wr_reg #(
  parameter int                DATA_W  = 64,
  parameter int                AW      = 3,
  parameter logic [DATA_W-1:0] RST_VAL = '0,
  parameter logic [DATA_W-1:0] VALID   = '1,
  parameter bit                HAS_AND = 1'b0,
  parameter bit                HAS_OR  = 1'b0,
  parameter int                OFF_D   = 0,
  parameter int                OFF_A   = 0,
  parameter int                OFF_O   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_off,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] hw_set,
  output logic [DATA_W-1:0] q
);
  logic              d_hit, a_hit, o_hit;
  logic [DATA_W-1:0] nxt;

  assign d_hit = wr_en && (wr_off == AW'(OFF_D));

  if (HAS_AND) begin : g_and
    assign a_hit = wr_en && (wr_off == AW'(OFF_A));
  end else begin : g_no_and
    assign a_hit = 1'b0;
  end

  if (HAS_OR) begin : g_or
    assign o_hit = wr_en && (wr_off == AW'(OFF_O));
  end else begin : g_no_or
    assign o_hit = 1'b0;
  end

  always_comb begin
    nxt = q;
    if (d_hit) nxt = wdata;
    if (a_hit) nxt = q & wdata;
    if (o_hit) nxt = q | wdata;
    // A hardware set is merged last so that it wins over any clear.
    nxt = (nxt | hw_set) & VALID;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST_VAL & VALID;
    else        q <= nxt;
  end
endmodule

// File: rtl/fir_attn_decode.sv
module fir_attn_decode #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] err,
  input  logic [DATA_W-1:0] msk,
  input  logic [DATA_W-1:0] act_a,
  input  logic [DATA_W-1:0] act_b,
  output logic [DATA_W-1:0] sys_vec,
  output logic [DATA_W-1:0] rec_vec,
  output logic [DATA_W-1:0] unit_vec,
  output logic              sys_q,
  output logic              rec_q,
  output logic              unit_q
);
  import fir_attn_pkg::*;

  for (genvar j = 0; j < DATA_W; j++) begin : g_bit
    fir_cls_e cls;
    assign cls         = classify(err[j], msk[j], act_a[j], act_b[j]);
    assign sys_vec[j]  = (cls == CLS_SYS);
    assign rec_vec[j]  = (cls == CLS_REC);
    assign unit_vec[j] = (cls == CLS_UNIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sys_q  <= 1'b0;
      rec_q  <= 1'b0;
      unit_q <= 1'b0;
    end else begin
      sys_q  <= |sys_vec;
      rec_q  <= |rec_vec;
      unit_q <= |unit_vec;
    end
  end
endmodule

// File: rtl/fir_attn_unit.sv
module fir_attn_unit #(
  parameter int DATA_W = 64,
  parameter int N_SRC  = 52
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_SRC-1:0]               err_pulse,
  input  logic                           reg_wr,
  input  logic [fir_attn_pkg::ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]              reg_wdata,
  output logic [DATA_W-1:0]              reg_rdata,
  output logic                           attn_sys_chk,
  output logic                           attn_recov,
  output logic                           attn_unit_chk
);
  import fir_attn_pkg::*;

  localparam logic [DATA_W-1:0] VALID = DATA_W'(valid_bits(DATA_W, N_SRC));

  logic [DATA_W-1:0] hw_set;
  logic [DATA_W-1:0] err_q, msk_q, act_a_q, act_b_q;
  logic [DATA_W-1:0] sys_vec, rec_vec, unit_vec;

  fir_src_map #(.DATA_W(DATA_W), .N_SRC(N_SRC)) u_map (
    .pulse(err_pulse), .set_vec(hw_set)
  );

  fir_wr_reg #(
    .DATA_W(DATA_W), .AW(ADDR_W), .RST_VAL('0), .VALID(VALID),
    .HAS_AND(1'b1), .HAS_OR(1'b1),
    .OFF_D(OFF_ERR), .OFF_A(OFF_ERR_AND), .OFF_O(OFF_ERR_OR)
  ) u_err (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_off(reg_addr),
    .wdata(reg_wdata), .hw_set(hw_set), .q(err_q)
  );

  fir_wr_reg #(
    .DATA_W(DATA_W), .AW(ADDR_W), .RST_VAL('1), .VALID(VALID),
    .HAS_AND(1'b1), .HAS_OR(1'b1),
    .OFF_D(OFF_MSK), .OFF_A(OFF_MSK_AND), .OFF_O(OFF_MSK_OR)
  ) u_msk (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_off(reg_addr),
    .wdata(reg_wdata), .hw_set('0), .q(msk_q)
  );

  fir_wr_reg #(
    .DATA_W(DATA_W), .AW(ADDR_W), .RST_VAL('0), .VALID(VALID),
    .HAS_AND(1'b0), .HAS_OR(1'b0), .OFF_D(OFF_ACT_A)
  ) u_act_a (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_off(reg_addr),
    .wdata(reg_wdata), .hw_set('0), .q(act_a_q)
  );

  fir_wr_reg #(
    .DATA_W(DATA_W), .AW(ADDR_W), .RST_VAL('0), .VALID(VALID),
    .HAS_AND(1'b0), .HAS_OR(1'b0), .OFF_D(OFF_ACT_B)
  ) u_act_b (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_off(reg_addr),
    .wdata(reg_wdata), .hw_set('0), .q(act_b_q)
  );

  fir_attn_decode #(.DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .err(err_q), .msk(msk_q), .act_a(act_a_q), .act_b(act_b_q),
    .sys_vec(sys_vec), .rec_vec(rec_vec), .unit_vec(unit_vec),
    .sys_q(attn_sys_chk), .rec_q(attn_recov), .unit_q(attn_unit_chk)
  );

  always_comb begin
    case (reg_addr)
      OFF_ERR, OFF_ERR_AND, OFF_ERR_OR: reg_rdata = err_q;
      OFF_MSK, OFF_MSK_AND, OFF_MSK_OR: reg_rdata = msk_q;
      OFF_ACT_A:                        reg_rdata = act_a_q;
      default:                          reg_rdata = act_b_q;
    endcase
  end
endmodule

// File: rtl/fir_attn_chk.sv
module fir_attn_chk #(
  parameter int DATA_W = 64,
  parameter int N_SRC  = 52
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] hw_set,
  input logic [DATA_W-1:0] err_q,
  input logic [DATA_W-1:0] msk_q,
  input logic [DATA_W-1:0] act_a_q,
  input logic [DATA_W-1:0] act_b_q,
  input logic              attn_sys_chk,
  input logic              attn_recov,
  input logic              attn_unit_chk
);
  import fir_attn_pkg::*;

  localparam logic [DATA_W-1:0] VALID = DATA_W'(valid_bits(DATA_W, N_SRC));

  logic err_wr;
  assign err_wr = reg_wr && (reg_addr == OFF_ERR || reg_addr == OFF_ERR_AND);

  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_q | msk_q | act_a_q | act_b_q) & ~VALID) == '0);

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !err_wr |=> ((err_q & $past(err_q)) == $past(err_q)));

  a_r7_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((err_q & $past(hw_set)) == $past(hw_set)));

  a_r5_mask_or: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_MSK_OR)
      |=> ((msk_q & $past(reg_wdata & VALID)) == $past(reg_wdata & VALID)));

  a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(err_q) && $stable(msk_q) && $stable(act_a_q) && $stable(act_b_q))
      |=> $stable({attn_sys_chk, attn_recov, attn_unit_chk}));

  a_r11_no_class: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_q & ~msk_q) == (err_q & ~msk_q & act_a_q & ~act_b_q))
      |=> !(attn_sys_chk || attn_recov || attn_unit_chk));
endmodule

bind fir_attn_unit fir_attn_chk #(.DATA_W(DATA_W), .N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .hw_set(hw_set), .err_q(err_q), .msk_q(msk_q),
  .act_a_q(act_a_q), .act_b_q(act_b_q), .attn_sys_chk(attn_sys_chk),
  .attn_recov(attn_recov), .attn_unit_chk(attn_unit_chk)
);

// File: tb/sim_fir_attn_unit.sv
module sim_fir_attn_unit;
  localparam logic [63:0] VALID = 64'hFFFF_FFFF_FFFF_F000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [51:0] err_pulse = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        attn_sys_chk, attn_recov, attn_unit_chk;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fir_attn_unit u0 (
    .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .attn_sys_chk(attn_sys_chk), .attn_recov(attn_recov),
    .attn_unit_chk(attn_unit_chk)
  );

  // {write offset, write data, read offset, expected read}
  localparam int NV = 9;
  localparam logic [133:0] VEC [NV] = '{
    {3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 64'hFFFF_FFFF_FFFF_F000},  // R4 R2
    {3'd1, 64'h0F0F_0F0F_0F0F_0F0F, 3'd0, 64'h0F0F_0F0F_0F0F_0000},  // R4
    {3'd2, 64'h8000_0000_0000_0001, 3'd1, 64'h8F0F_0F0F_0F0F_0000},  // R4 R6
    {3'd0, 64'h0000_0000_0000_0000, 3'd2, 64'h0000_0000_0000_0000},  // R4 R6
    {3'd3, 64'h0000_0000_0000_0000, 3'd3, 64'h0000_0000_0000_0000},  // R5
    {3'd5, 64'h00FF_0000_0000_00FF, 3'd3, 64'h00FF_0000_0000_0000},  // R5
    {3'd4, 64'hF0F0_FFFF_FFFF_FFFF, 3'd4, 64'h00F0_0000_0000_0000},  // R5
    {3'd6, 64'h1234_5678_9ABC_DEF1, 3'd6, 64'h1234_5678_9ABC_D000},  // R6
    {3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 3'd7, 64'hFFFF_FFFF_FFFF_F000}   // R6
  };

  task automatic check(input string req, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [2:0] a,
                          input logic [63:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic pulse(input int src);
    @(negedge clk);
    err_pulse[src] = 1'b1;
    @(negedge clk);
    err_pulse = '0;
  endtask

  task automatic attn_chk(input string req, input logic [2:0] exp);
    check(req, {61'd0, attn_sys_chk, attn_recov, attn_unit_chk}, {61'd0, exp});
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    read_chk("R1 err", 3'd0, 64'h0);
    read_chk("R1 mask", 3'd3, VALID);
    read_chk("R1 actA", 3'd6, 64'h0);
    read_chk("R1 actB", 3'd7, 64'h0);
    attn_chk("R1 attn", 3'b000);

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][133:131], VEC[i][130:67]);
      read_chk($sformatf("R4/R5/R6 vector %0d", i), VEC[i][66:64], VEC[i][63:0]);
    end

    // Return to reset state, then unmask everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    do_write(3'd3, 64'h0);

    // R2 R3 R12: source 0 lands on bit 63; attention one edge later
    pulse(0);
    read_chk("R2 src0 pos", 3'd0, 64'h8000_0000_0000_0000);
    attn_chk("R12 latency", 3'b000);
    @(negedge clk);
    attn_chk("R8 sys", 3'b100);
    repeat (4) @(negedge clk);
    read_chk("R3 sticky", 3'd0, 64'h8000_0000_0000_0000);

    do_write(3'd7, 64'h8000_0000_0000_0000);
    attn_chk("R12 still old", 3'b100);
    @(negedge clk);
    attn_chk("R9 recov", 3'b010);

    do_write(3'd6, 64'h8000_0000_0000_0000);
    @(negedge clk);
    attn_chk("R10 unit", 3'b001);

    do_write(3'd7, 64'h0);
    @(negedge clk);
    attn_chk("R11 A only", 3'b000);

    do_write(3'd6, 64'h0);
    @(negedge clk);
    attn_chk("R8 sys again", 3'b100);

    do_write(3'd5, 64'h8000_0000_0000_0000);
    @(negedge clk);
    attn_chk("R8 masked", 3'b000);
    do_write(3'd4, 64'h0);
    read_chk("R5 mask and-clear", 3'd3, 64'h0);

    // R2 last source maps to bit 12
    pulse(51);
    read_chk("R2 src51 pos", 3'd0, 64'h8000_0000_0000_1000);

    // R7: AND-clear with simultaneous pulse on source 5 (bit 58)
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 64'h0; err_pulse[5] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; err_pulse = '0;
    read_chk("R7 set wins", 3'd0, 64'h0400_0000_0000_0000);

    // R2 unused bits ignore writes
    do_write(3'd2, 64'h0000_0000_0000_0FFF);
    read_chk("R2 unused write", 3'd0, 64'h0400_0000_0000_0000);
    do_write(3'd1, 64'h0);
    @(negedge clk);
    attn_chk("R4 clear drops attn", 3'b000);

    finish_run();
  end
endmodule